// File: doc/BRIEF.md
# Direct-Mapped Cache with Miss Classification

This block is a small read-only cache with one line per set, sitting in front of a tiny byte-addressed backing store. A requester presents an address with a valid/ready handshake. The cache splits the address into tag, set index and byte offset. It checks the single line of the indexed set and returns the addressed byte. It also returns a result code that either reports a hit or names the kind of miss.

Every miss is sorted into one of three kinds. A first-touch record with one bit per memory block detects the first reference to a block. A fully associative least-recently-used directory of block numbers, holding as many entries as the cache has lines, separates the other misses. If that directory still holds the block, the miss came from set mapping; if it does not, the miss came from too little total room. Line fills use a one-block request/response port to the backing store. A side read port shows the valid bit, tag and data of any set, so the contents can be inspected.

Top module: `dmc_missclass`

## Requirements
- R1: The address holds the byte offset in its lowest bits, the set index above it and the tag in the highest bits. The defaults are a 4-bit address, 4 sets and 2-byte lines, so the offset is bit 0, the index is bits 2:1 and the tag is bit 3. The block number sent on `mem_req_blk` is the address with the offset removed (bits 3:1).
- R2: After reset every line is invalid, no block counts as referenced, `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0.
- R3: A request is a hit when the indexed line is valid and its stored tag equals the address tag. The response comes one cycle after acceptance, with `rsp_hit`=1, `rsp_kind`=0 and the byte chosen by the offset. Byte k of a line sits at bits 8k+7:8k.
- R4: On a miss, `req_ready` goes low and `mem_req_valid` is raised with the block number until `mem_rsp_valid` arrives. The indexed line then takes the new data and tag and becomes valid. The response, with `rsp_hit`=0, comes one cycle after the cycle that carried `mem_rsp_valid`.
- R5: A miss on the first reference since reset to a memory block reports `rsp_kind`=1 (cold).
- R6: A miss on a block that was referenced before and is among the last SET_CNT distinct blocks referenced (hits and misses both count) reports `rsp_kind`=2 (conflict).
- R7: Any other miss reports `rsp_kind`=3 (capacity).
- R8: With the defaults, reading addresses 0, 1, 7, 8, 0 from reset gives cold, hit, cold, cold, conflict.
- R9: After the sequence of R8, sets 0 and 3 are valid with tag 0 and hold bytes 0–1 and 6–7; sets 1 and 2 are invalid.
- R10: A request presented while `req_ready` is low is not accepted. It changes neither the responses nor the referenced-block record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Cache can accept a request |
| req_addr | input | ADDR_W | Byte address of the read |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_data | output | 8 | Byte read |
| rsp_hit | output | 1 | 1 on hit |
| rsp_kind | output | 2 | 0 hit, 1 cold, 2 conflict, 3 capacity |
| mem_req_valid | output | 1 | Fill request to the backing store |
| mem_req_blk | output | ADDR_W-OFF_W | Block number to fetch |
| mem_rsp_valid | input | 1 | Fill data present |
| mem_rsp_data | input | 8*BLK_BYTES | Whole block, byte k at bits 8k+7:8k |
| dbg_set | input | IDX_W | Set selected on the inspection port |
| dbg_valid | output | 1 | Valid bit of that set |
| dbg_tag | output | TAG_W | Stored tag of that set |
| dbg_line | output | 8*BLK_BYTES | Stored data of that set |

## Verification
A hit response is due one cycle after the edge that accepts the request. A miss response is due one cycle after the edge that consumes `mem_rsp_valid`, so the delay of a miss depends on the backing-store model. The bench does not count cycles. It pushes the expected byte, hit flag and miss kind when it drives a request. It compares them whenever it sees `rsp_valid` at a falling edge, so order and one-cycle pulse width are checked for any latency. The fill request is checked at the falling edge right after acceptance, and the inspection port is read only while the cache is idle.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    typedef enum logic [1:0] {
        KIND_HIT      = 2'd0,
        KIND_COLD     = 2'd1,
        KIND_CONFLICT = 2'd2,
        KIND_CAPACITY = 2'd3
    } miss_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } ctl_state_e;

endpackage

// File: rtl/dmc_line_store.sv
module dmc_line_store #(
    parameter int SET_CNT = 4,
    parameter int TAG_W   = 1,
    parameter int LINE_W  = 16,
    localparam int IDX_W  = (SET_CNT > 1) ? $clog2(SET_CNT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    output logic [LINE_W-1:0] lk_line,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [LINE_W-1:0] fill_line,
    input  logic [IDX_W-1:0]  peek_idx,
    output logic              peek_valid,
    output logic [TAG_W-1:0]  peek_tag,
    output logic [LINE_W-1:0] peek_line
);

    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [LINE_W-1:0] data;
    } line_t;

    line_t [SET_CNT-1:0] lines_d, lines_q;

    always_comb begin
        lines_d = lines_q;
        if (fill_en) begin
            lines_d[fill_idx].valid = 1'b1;
            lines_d[fill_idx].tag   = fill_tag;
            lines_d[fill_idx].data  = fill_line;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lines_q <= '0;
        else        lines_q <= lines_d;
    end

    assign lk_hit     = lines_q[lk_idx].valid && (lines_q[lk_idx].tag == lk_tag);
    assign lk_line    = lines_q[lk_idx].data;
    assign peek_valid = lines_q[peek_idx].valid;
    assign peek_tag   = lines_q[peek_idx].tag;
    assign peek_line  = lines_q[peek_idx].data;

endmodule

// File: rtl/dmc_first_touch.sv
module dmc_first_touch #(
    parameter int BLK_W   = 3,
    localparam int BLK_CNT = 1 << BLK_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BLK_W-1:0] probe_blk,
    input  logic             mark_en,
    output logic             probe_seen
);

    logic [BLK_CNT-1:0] seen_d, seen_q;

    always_comb begin
        seen_d = seen_q;
        if (mark_en) seen_d[probe_blk] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= '0;
        else        seen_q <= seen_d;
    end

    assign probe_seen = seen_q[probe_blk];

endmodule

// File: rtl/dmc_shadow_lru.sv
module dmc_shadow_lru #(
    parameter int WAYS   = 4,
    parameter int BLK_W  = 3,
    localparam int RANK_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BLK_W-1:0] probe_blk,
    input  logic             touch_en,
    output logic             probe_hit
);

    typedef struct packed {
        logic              valid;
        logic [BLK_W-1:0]  blk;
        logic [RANK_W-1:0] rank;
    } entry_t;

    entry_t [WAYS-1:0] ent_d, ent_q;
    logic   [WAYS-1:0] match;
    logic [RANK_W-1:0] hit_rank;

    for (genvar w = 0; w < WAYS; w++) begin : g_match
        assign match[w] = ent_q[w].valid && (ent_q[w].blk == probe_blk);
    end

    assign probe_hit = |match;

    always_comb begin
        hit_rank = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) hit_rank = hit_rank | ent_q[w].rank;
        end
    end

    always_comb begin
        ent_d = ent_q;
        if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (probe_hit) begin
                    if (match[w])                       ent_d[w].rank = '0;
                    else if (ent_q[w].rank < hit_rank)  ent_d[w].rank = ent_q[w].rank + 1'b1;
                end else begin
                    if (ent_q[w].rank == RANK_W'(WAYS - 1)) begin
                        ent_d[w].valid = 1'b1;
                        ent_d[w].blk   = probe_blk;
                        ent_d[w].rank  = '0;
                    end else begin
                        ent_d[w].rank  = ent_q[w].rank + 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WAYS; w++) begin
                ent_q[w].valid <= 1'b0;
                ent_q[w].blk   <= '0;
                ent_q[w].rank  <= RANK_W'(w);
            end
        end else begin
            ent_q <= ent_d;
        end
    end

endmodule

// File: rtl/dmc_missclass.sv
module dmc_missclass
    import dmc_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int SET_CNT   = 4,
    parameter int BLK_BYTES = 2,
    localparam int OFF_W  = (BLK_BYTES > 1) ? $clog2(BLK_BYTES) : 1,
    localparam int IDX_W  = (SET_CNT > 1) ? $clog2(SET_CNT) : 1,
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
    localparam int BLK_W  = ADDR_W - OFF_W,
    localparam int LINE_W = 8 * BLK_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [7:0]        rsp_data,
    output logic              rsp_hit,
    output logic [1:0]        rsp_kind,
    output logic              mem_req_valid,
    output logic [BLK_W-1:0]  mem_req_blk,
    input  logic              mem_rsp_valid,
    input  logic [LINE_W-1:0] mem_rsp_data,
    input  logic [IDX_W-1:0]  dbg_set,
    output logic              dbg_valid,
    output logic [TAG_W-1:0]  dbg_tag,
    output logic [LINE_W-1:0] dbg_line
);

    typedef struct packed {
        ctl_state_e       st;
        logic             rsp_valid;
        logic             rsp_hit;
        miss_kind_e       kind;
        logic [7:0]       rsp_byte;
        logic [IDX_W-1:0] idx;
        logic [TAG_W-1:0] tag;
        logic [OFF_W-1:0] off;
        logic [BLK_W-1:0] blk;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [OFF_W-1:0]  req_off;
    logic [IDX_W-1:0]  req_idx;
    logic [TAG_W-1:0]  req_tag;
    logic [BLK_W-1:0]  req_blk;
    logic              accept;
    logic              lookup_hit;
    logic [LINE_W-1:0] lookup_line;
    logic              blk_seen;
    logic              shadow_hit;
    logic              fill_en;

    assign req_off = req_addr[OFF_W-1:0];
    assign req_idx = req_addr[OFF_W +: IDX_W];
    assign req_tag = req_addr[ADDR_W-1 -: TAG_W];
    assign req_blk = req_addr[ADDR_W-1:OFF_W];

    assign req_ready = (c_q.st == ST_IDLE);
    assign accept    = req_valid && req_ready;

    dmc_line_store #(
        .SET_CNT (SET_CNT),
        .TAG_W   (TAG_W),
        .LINE_W  (LINE_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_idx     (req_idx),
        .lk_tag     (req_tag),
        .lk_hit     (lookup_hit),
        .lk_line    (lookup_line),
        .fill_en    (fill_en),
        .fill_idx   (c_q.idx),
        .fill_tag   (c_q.tag),
        .fill_line  (mem_rsp_data),
        .peek_idx   (dbg_set),
        .peek_valid (dbg_valid),
        .peek_tag   (dbg_tag),
        .peek_line  (dbg_line)
    );

    dmc_first_touch #(
        .BLK_W (BLK_W)
    ) u_touch (
        .clk        (clk),
        .rst_n      (rst_n),
        .probe_blk  (req_blk),
        .mark_en    (accept),
        .probe_seen (blk_seen)
    );

    dmc_shadow_lru #(
        .WAYS  (SET_CNT),
        .BLK_W (BLK_W)
    ) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .probe_blk (req_blk),
        .touch_en  (accept),
        .probe_hit (shadow_hit)
    );

    always_comb begin
        c_d           = c_q;
        c_d.rsp_valid = 1'b0;
        fill_en       = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (accept) begin
                    if (lookup_hit) begin
                        c_d.rsp_valid = 1'b1;
                        c_d.rsp_hit   = 1'b1;
                        c_d.kind      = KIND_HIT;
                        c_d.rsp_byte  = lookup_line[{req_off, 3'b000} +: 8];
                    end else begin
                        c_d.st      = ST_FILL;
                        c_d.rsp_hit = 1'b0;
                        c_d.idx     = req_idx;
                        c_d.tag     = req_tag;
                        c_d.off     = req_off;
                        c_d.blk     = req_blk;
                        if (!blk_seen)       c_d.kind = KIND_COLD;
                        else if (shadow_hit) c_d.kind = KIND_CONFLICT;
                        else                 c_d.kind = KIND_CAPACITY;
                    end
                end
            end
            ST_FILL: begin
                if (mem_rsp_valid) begin
                    fill_en       = 1'b1;
                    c_d.rsp_valid = 1'b1;
                    c_d.rsp_byte  = mem_rsp_data[{c_q.off, 3'b000} +: 8];
                    c_d.st        = ST_IDLE;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q      <= '0;
            c_q.st   <= ST_IDLE;
            c_q.kind <= KIND_HIT;
        end else begin
            c_q <= c_d;
        end
    end

    assign rsp_valid     = c_q.rsp_valid;
    assign rsp_data      = c_q.rsp_byte;
    assign rsp_hit       = c_q.rsp_hit;
    assign rsp_kind      = c_q.kind;
    assign mem_req_valid = (c_q.st == ST_FILL);
    assign mem_req_blk   = c_q.blk;

endmodule

// File: rtl/dmc_missclass_chk.sv
module dmc_missclass_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_ready,
    input logic       accept,
    input logic       lookup_hit,
    input logic       mem_req_valid,
    input logic       mem_rsp_valid,
    input logic       rsp_valid,
    input logic       rsp_hit,
    input logic [1:0] rsp_kind
);

    a_r3_hit_answers_next: assert property (@(posedge clk) disable iff (!rst_n)
        accept && lookup_hit |=> rsp_valid && rsp_hit && (rsp_kind == 2'd0));

    a_r4_miss_opens_fill: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !lookup_hit |=> mem_req_valid && !rsp_valid);

    a_r4_fill_stalls_requests: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    a_r4_fill_then_answer: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_rsp_valid |=> rsp_valid && !rsp_hit && !mem_req_valid);

    a_r5_kind_agrees_with_hit: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit == (rsp_kind == 2'd0)));

endmodule

bind dmc_missclass dmc_missclass_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_ready     (req_ready),
    .accept        (accept),
    .lookup_hit    (lookup_hit),
    .mem_req_valid (mem_req_valid),
    .mem_rsp_valid (mem_rsp_valid),
    .rsp_valid     (rsp_valid),
    .rsp_hit       (rsp_hit),
    .rsp_kind      (rsp_kind)
);

// File: tb/dmc_missclass_tb_top.sv
module dmc_missclass_tb_top;

    localparam int ADDR_W = 4;
    localparam int SETS   = 4;
    localparam int NBLK   = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_addr = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_data;
    logic        rsp_hit;
    logic [1:0]  rsp_kind;
    logic        mem_req_valid;
    logic [2:0]  mem_req_blk;
    logic        mem_rsp_valid = 1'b0;
    logic [15:0] mem_rsp_data = '0;
    logic [1:0]  dbg_set = '0;
    logic        dbg_valid;
    logic [0:0]  dbg_tag;
    logic [15:0] dbg_line;

    always #5ns clk = ~clk;

    dmc_missclass dut_i (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready), .req_addr (req_addr),
        .rsp_valid (rsp_valid), .rsp_data (rsp_data), .rsp_hit (rsp_hit), .rsp_kind (rsp_kind),
        .mem_req_valid (mem_req_valid), .mem_req_blk (mem_req_blk),
        .mem_rsp_valid (mem_rsp_valid), .mem_rsp_data (mem_rsp_data),
        .dbg_set (dbg_set), .dbg_valid (dbg_valid), .dbg_tag (dbg_tag), .dbg_line (dbg_line)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    typedef struct {
        logic [7:0] b;
        logic       h;
        logic [1:0] k;
        string      lbl;
    } exp_t;
    exp_t sb[$];

    bit m_valid [SETS];
    int m_tag   [SETS];
    bit m_seen  [NBLK];
    int m_shadow[$];

    function automatic logic [7:0] mbyte(int a);
        return 8'(a * 29 + 7);
    endfunction

    task automatic chk(string lbl, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", lbl, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < SETS; i++) m_valid[i] = 0;
        for (int i = 0; i < NBLK; i++) m_seen[i] = 0;
        m_shadow.delete();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    // Driver: compute expectation, push it, then run the handshake.
    task automatic do_read(int a, string lbl);
        exp_t e;
        int idx, tg, blk, pos;
        bit hit;
        idx = (a >> 1) & 3;
        tg  = a >> 3;
        blk = a >> 1;
        hit = m_valid[idx] && (m_tag[idx] == tg);
        pos = -1;
        foreach (m_shadow[i]) if (m_shadow[i] == blk) pos = i;
        e.b = mbyte(a);
        e.h = hit;
        if (hit)             begin e.k = 2'd0; e.lbl = {lbl, " R3 hit"}; end
        else if (!m_seen[blk]) begin e.k = 2'd1; e.lbl = {lbl, " R5 cold"}; end
        else if (pos >= 0)   begin e.k = 2'd2; e.lbl = {lbl, " R6 conflict"}; end
        else                 begin e.k = 2'd3; e.lbl = {lbl, " R7 capacity"}; end
        m_seen[blk] = 1;
        if (pos >= 0) m_shadow.delete(pos);
        m_shadow.push_front(blk);
        if (m_shadow.size() > SETS) void'(m_shadow.pop_back());
        if (!hit) begin m_valid[idx] = 1; m_tag[idx] = tg; end
        sb.push_back(e);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = 4'(a);
        @(negedge clk);
        req_valid = 1'b0;
        if (!hit) begin
            chk("R4 fill request raised", 32'(mem_req_valid), 32'd1);
            chk("R4 ready low during fill", 32'(req_ready), 32'd0);
            chk("R1 fill block number", 32'(mem_req_blk), 32'(blk));
        end
    endtask

    task automatic drain();
        int guard = 0;
        while (sb.size() != 0 && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        repeat (2) @(negedge clk);
        chk("R4 all responses delivered", 32'(sb.size()), 32'd0);
    endtask

    // Backing store model: answers a fill a few cycles after the request.
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req_valid && !mem_rsp_valid) begin
                int b;
                b = int'(mem_req_blk);
                repeat (2) @(negedge clk);
                mem_rsp_data  = {mbyte(2 * b + 1), mbyte(2 * b)};
                mem_rsp_valid = 1'b1;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
            end
        end
    end

    // Monitor: pop and compare every response.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rsp_valid) begin
                if (sb.size() == 0) begin
                    n_tests++;
                    n_fail++;
                    $display("FAIL R10 unexpected response: actual data %0h expected none", rsp_data);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk({e.lbl, " data"}, 32'(rsp_data), 32'(e.b));
                    chk({e.lbl, " hit flag"}, 32'(rsp_hit), 32'(e.h));
                    chk({e.lbl, " kind"}, 32'(rsp_kind), 32'(e.k));
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] lf;
        do_reset();
        @(negedge clk);
        chk("R2 ready after reset", 32'(req_ready), 32'd1);
        chk("R2 no response after reset", 32'(rsp_valid), 32'd0);
        chk("R2 no fill after reset", 32'(mem_req_valid), 32'd0);
        for (int s = 0; s < SETS; s++) begin
            dbg_set = 2'(s);
            #1ns;
            chk("R2 line invalid after reset", 32'(dbg_valid), 32'd0);
        end

        // R8 trace: cold, hit, cold, cold, conflict
        do_read(0, "R8");
        do_read(1, "R8");
        do_read(7, "R8");
        do_read(8, "R8");
        do_read(0, "R8");
        drain();

        // R9 final contents
        dbg_set = 2'd0; #1ns;
        chk("R9 set0 valid", 32'(dbg_valid), 32'd1);
        chk("R9 set0 tag", 32'(dbg_tag), 32'd0);
        chk("R9 set0 data", 32'(dbg_line), 32'({mbyte(1), mbyte(0)}));
        dbg_set = 2'd1; #1ns;
        chk("R9 set1 invalid", 32'(dbg_valid), 32'd0);
        dbg_set = 2'd2; #1ns;
        chk("R9 set2 invalid", 32'(dbg_valid), 32'd0);
        dbg_set = 2'd3; #1ns;
        chk("R9 set3 valid", 32'(dbg_valid), 32'd1);
        chk("R9 set3 tag", 32'(dbg_tag), 32'd0);
        chk("R9 set3 data", 32'(dbg_line), 32'({mbyte(7), mbyte(6)}));

        // R7: five distinct blocks overflow four lines, then revisit
        do_reset();
        do_read(0, "R7 sweep");
        do_read(2, "R7 sweep");
        do_read(4, "R7 sweep");
        do_read(6, "R7 sweep");
        do_read(8, "R7 sweep");
        do_read(0, "R7 sweep");
        do_read(3, "R7 sweep");
        do_read(5, "R7 sweep");
        drain();

        // R10: request held while ready is low is ignored
        do_read(10, "R10 first");
        req_valid = 1'b1;
        req_addr  = 4'd14;
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        drain();
        do_read(14, "R10 later");
        drain();

        // Mixed traffic
        lf = 8'hA5;
        for (int i = 0; i < 300; i++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            do_read(int'(lf[3:0]), "R1 mixed");
        end
        drain();

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule